// File: doc/BRIEF.md
# Key-protected watchdog timer

This peripheral counts clock cycles with a 16-bit up-counter that stops at its maximum value. It compares the count against two programmable limits. The lower limit raises an early-warning flag, which can drive an interrupt. The upper limit drives a reset request for as long as the timer runs at or past it. Software has to service the timer before the upper limit is reached, or the system is reset.

A single register bus reaches every register. Nothing changes the timer's behaviour directly. Software first writes the arm value 0xA5 to the key register and then writes one command value. The commands start, stop or refresh the counter, grant permission for one register write, or lock the register file until the next reset. A debug-halt input can freeze the count, and a control bit selects whether it does.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, control and thresholds read 0 and the key register reads 0. Status reads 0x08, because the count of 0 already meets the zero upper limit. `irq` and `rst_req` are low.
- R2: Writing 0xA5 to the key register (offset 0x30) arms the key logic, and status bit 0 then reads 1. The next key write of any value disarms it. A key write other than 0xA5 while disarmed leaves it disarmed and has no effect.
- R3: After arming, 0xEE starts the timer, 0xDD stops it and 0xCC clears the count. A running timer counts up once per clock cycle. An unrecognised value after arming changes nothing.
- R4: After arming, 0xF1 sets status bit 1. The next write to offset 0x00 (control), 0x10 (status) or 0x20 (thresholds) takes effect and clears that bit. A register write made without this permission is ignored.
- R5: After arming, 0xFF locks the block until reset. Permission is withdrawn, 0xF1 no longer grants it, and register writes are ignored. The start, stop and refresh commands still work.
- R6: The threshold register holds the early-warning limit in bits 15:0 and the reset limit in bits 31:16. After a write to it, status bit 4 reads 1 for two cycles. The comparators use the new limits from the second clock edge after the write.
- R7: Status bit 2 sets while the timer runs and the count equals the early-warning limit. A permitted status write with bit 2 equal to 0 clears the flag, and with bit 2 equal to 1 sets it.
- R8: `irq` equals status bit 2 ANDed with control bit 0.
- R9: Status bit 3 reads 1 while the count is at or above the reset limit. `rst_req` is high when that holds and the timer is running.
- R10: With control bit 1 set, the count holds while `dbg_halt` is high. With control bit 1 clear, `dbg_halt` has no effect on the count.
- R11: The count saturates at 0xFFFF and never wraps to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dbg_halt | input | 1 | Debug halt from the core |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | Reset request |

## Verification
The hardest situation to reach is saturation at 0xFFFF. The count cannot be read, so the only way to observe saturation is to watch `rst_req` stay high. The bench programs the reset limit to 0xFFFF and lets the timer run the full 65,535 cycles. It checks that `rst_req` is low one cycle before the limit and high at the limit. It then checks that `rst_req` is still high 200 cycles later, which would fail if the counter had wrapped. The timing of the debug freeze is inferred the same way. The bench measures how long `rst_req` takes to rise with and without a ten-cycle halt.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_halt,
  output logic              irq,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_THR  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] OFS_KEY  = ADDR_W'('h30);
  localparam logic [7:0] K_ARM = 8'hA5, K_CLR = 8'hCC, K_STOP = 8'hDD,
                         K_GO  = 8'hEE, K_PERM = 8'hF1, K_LOCK = 8'hFF;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]         ctrl;
  logic [2*CNT_W-1:0] thr_reg, thr_eff;
  logic [1:0]         upd_cnt;
  logic [CNT_W-1:0]   cnt;
  logic armed, wr_ok, locked, running, ew_flag;

  wire key_wr     = bus_we && bus_addr == OFS_KEY;
  wire [7:0] key  = bus_wdata[7:0];
  wire cmd_go     = key_wr && armed && key == K_GO;
  wire cmd_stop   = key_wr && armed && key == K_STOP;
  wire cmd_clr    = key_wr && armed && key == K_CLR;
  wire cmd_perm   = key_wr && armed && key == K_PERM;
  wire cmd_lock   = key_wr && armed && key == K_LOCK;
  wire reg_sel    = bus_addr == OFS_CTRL || bus_addr == OFS_STAT || bus_addr == OFS_THR;
  wire reg_wr     = bus_we && reg_sel && wr_ok && !locked;
  wire thr_wr     = reg_wr && bus_addr == OFS_THR;
  wire frozen     = ctrl[1] && dbg_halt;
  wire [CNT_W-1:0] ew_lim  = thr_eff[CNT_W-1:0];
  wire [CNT_W-1:0] rst_lim = thr_eff[2*CNT_W-1:CNT_W];
  wire at_rst     = cnt >= rst_lim;
  wire ew_hit     = running && cnt == ew_lim;

  assign irq     = ew_flag && ctrl[0];
  assign rst_req = running && at_rst;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: bus_rdata[1:0] = ctrl;
      OFS_STAT: bus_rdata[4:0] = {upd_cnt != 2'd0, at_rst, ew_flag, wr_ok, armed};
      OFS_THR:  bus_rdata[2*CNT_W-1:0] = thr_reg;
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; wr_ok <= 1'b0; locked <= 1'b0; running <= 1'b0;
    end else begin
      if (key_wr) armed <= !armed && key == K_ARM;
      if (cmd_go) running <= 1'b1;
      if (cmd_stop) running <= 1'b0;
      if (cmd_perm && !locked) wr_ok <= 1'b1;
      if (cmd_lock) begin
        locked <= 1'b1;
        wr_ok  <= 1'b0;
      end
      if (bus_we && reg_sel) wr_ok <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; thr_reg <= '0; thr_eff <= '0; upd_cnt <= '0; ew_flag <= 1'b0;
    end else begin
      if (reg_wr && bus_addr == OFS_CTRL) ctrl <= bus_wdata[1:0];
      if (reg_wr && bus_addr == OFS_STAT) ew_flag <= bus_wdata[2];
      else if (ew_hit) ew_flag <= 1'b1;
      if (thr_wr) begin
        thr_reg <= bus_wdata[2*CNT_W-1:0];
        upd_cnt <= 2'd2;
      end else if (upd_cnt != 2'd0) begin
        upd_cnt <= upd_cnt - 2'd1;
        if (upd_cnt == 2'd1) thr_eff <= thr_reg;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cmd_clr) cnt <= '0;
    else if (running && !frozen && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  AST_ARM_ONCE: assert property (@(posedge clk) disable iff (!rst_n) (key_wr && armed) |=> !armed); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !frozen && cnt != CNT_MAX && !cmd_clr) |=> cnt == $past(cnt) + 1'b1); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) locked |=> locked); // R5
  AST_LOCK_NOPERM: assert property (@(posedge clk) disable iff (!rst_n) locked |-> !wr_ok); // R5
  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_cnt == 2'd0 && !thr_wr) |=> $stable(thr_eff)); // R6
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (frozen && !cmd_clr) |=> $stable(cnt)); // R10
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (cnt == CNT_MAX && !cmd_clr) |=> cnt == CNT_MAX); // R11
endmodule

// File: tb/wdt_keyed_test.sv
module wdt_keyed_test;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, dbg_halt = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, rst_req;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  wdt_keyed uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
    .irq(irq), .rst_req(rst_req));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic key(input logic [7:0] k); wr(8'h30, {24'h0, k}); endtask
  task automatic cmd(input logic [7:0] k); key(8'hA5); key(k); endtask
  task automatic pwr(input logic [7:0] a, input logic [31:0] d); cmd(8'hF1); wr(a, d); endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0; bus_we = 1'b0; dbg_halt = 1'b0;
    wt(2); rst_n = 1'b1; wt(1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    do_reset;
    rd(8'h00, v); chk_eq("R1 ctrl", v, 0);
    rd(8'h10, v); chk_eq("R1 status", v, 32'h08);
    rd(8'h20, v); chk_eq("R1 thr", v, 0);
    rd(8'h30, v); chk_eq("R1 key", v, 0);
    chk_eq("R1 irq", {31'b0, irq}, 0);
    chk_eq("R1 rst_req", {31'b0, rst_req}, 0);
  endtask

  task automatic t_keys;
    logic [31:0] v;
    do_reset;
    key(8'hF1); rd(8'h10, v); chk_eq("R2 non-arm idle", v[1:0], 0);
    key(8'hA5); rd(8'h10, v); chk_eq("R2 armed", v[0], 1);
    key(8'h12); rd(8'h10, v); chk_eq("R2 unknown disarms", v[1:0], 0);
    key(8'hEE); chk_eq("R3 unarmed start ignored", rst_req, 0);
    wr(8'h00, 32'h3); rd(8'h00, v); chk_eq("R4 write without permission", v, 0);
  endtask

  task automatic t_perm;
    logic [31:0] v;
    do_reset;
    cmd(8'hF1); rd(8'h10, v); chk_eq("R4 permission", v[1], 1);
    wr(8'h00, 32'h1); rd(8'h00, v); chk_eq("R4 write taken", v, 1);
    rd(8'h10, v); chk_eq("R4 permission consumed", v[1], 0);
    wr(8'h00, 32'h0); rd(8'h00, v); chk_eq("R4 second write ignored", v, 1);
  endtask

  task automatic t_thr;
    logic [31:0] v;
    do_reset;
    pwr(8'h20, 32'h0005_0003);
    rd(8'h10, v); chk_eq("R6 updating e0", v[4:3], 2'b11);
    wt(1); rd(8'h10, v); chk_eq("R6 updating e1", v[4:3], 2'b11);
    wt(1); rd(8'h10, v); chk_eq("R6 applied", v[4:3], 2'b00);
    rd(8'h20, v); chk_eq("R6 thr layout", v, 32'h0005_0003);
  endtask

  task automatic t_run_stop_clear;
    do_reset;
    pwr(8'h20, 32'h000A_FFF0); wt(2);
    cmd(8'hEE);
    wt(9); chk_eq("R3 count 9", rst_req, 0);
    wt(1); chk_eq("R9 rst_req at limit", rst_req, 1);
    cmd(8'hDD); chk_eq("R9 stopped no rst_req", rst_req, 0);
    cmd(8'hCC); cmd(8'hEE);
    wt(6); chk_eq("R3 cleared restart", rst_req, 0);
    cmd(8'hCC); wt(5); cmd(8'hCC); wt(5);
    chk_eq("R3 refresh holds off", rst_req, 0);
    cmd(8'h33); wt(4); chk_eq("R3 unknown command no effect", rst_req, 1);
  endtask

  task automatic t_ew;
    logic [31:0] v;
    do_reset;
    pwr(8'h20, 32'h0064_0008); wt(2);
    pwr(8'h00, 32'h1);
    cmd(8'hEE);
    wt(8); rd(8'h10, v); chk_eq("R7 flag before match", v[2], 0);
    wt(1); rd(8'h10, v); chk_eq("R7 flag on match", v[2], 1);
    chk_eq("R8 irq", irq, 1);
    pwr(8'h10, 32'h0); rd(8'h10, v); chk_eq("R7 cleared", v[2], 0);
    chk_eq("R8 irq low", irq, 0);
    pwr(8'h10, 32'h4); rd(8'h10, v); chk_eq("R7 forced", v[2], 1);
    pwr(8'h00, 32'h0); rd(8'h10, v);
    chk_eq("R8 masked irq", {v[2], irq}, 2'b10);
  endtask

  task automatic t_lock;
    logic [31:0] v;
    do_reset;
    cmd(8'hF1); cmd(8'hFF);
    rd(8'h10, v); chk_eq("R5 permission withdrawn", v[1], 0);
    cmd(8'hF1); rd(8'h10, v); chk_eq("R5 no grant after lock", v[1], 0);
    wr(8'h00, 32'h3); rd(8'h00, v); chk_eq("R5 write ignored", v, 0);
    cmd(8'hEE); chk_eq("R5 start still works", rst_req, 1);
    do_reset; pwr(8'h00, 32'h2); rd(8'h00, v); chk_eq("R5 reset unlocks", v, 2);
  endtask

  task automatic t_dbg(input bit mode);
    do_reset;
    pwr(8'h20, 32'h0014_FFF0); wt(2);
    pwr(8'h00, {30'b0, mode, 1'b0});
    cmd(8'hEE);
    wt(5); dbg_halt = 1'b1; wt(10); dbg_halt = 1'b0;
    if (mode) begin
      wt(14); chk_eq("R10 frozen delay", rst_req, 0);
      wt(1);  chk_eq("R10 frozen reach", rst_req, 1);
    end else begin
      wt(4); chk_eq("R10 run-through before", rst_req, 0);
      wt(1); chk_eq("R10 run-through reach", rst_req, 1);
    end
  endtask

  task automatic t_sat;
    logic [31:0] v;
    do_reset;
    pwr(8'h20, 32'hFFFF_FFF0); wt(2);
    cmd(8'hEE);
    wt(65534); chk_eq("R11 below max", rst_req, 0);
    wt(1); chk_eq("R11 at max", rst_req, 1);
    wt(200); chk_eq("R11 no wrap", rst_req, 1);
    rd(8'h10, v); chk_eq("R9 status at limit", v[3], 1);
  endtask

  initial begin
    fork
      begin
        t_reset; t_keys; t_perm; t_thr; t_run_stop_clear;
        t_ew; t_lock; t_dbg(1'b1); t_dbg(1'b0); t_sat;
      end
      begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule